// File: doc/BRIEF.md
# Configuration-Triggered Register Burst Streamer

This block sends an unsolicited packet of register words each time its configuration word is written. Every packet opens with two header words at fixed register addresses. The first header word gives the start address and the length of the payload. The second header word carries a masked copy of the configuration word. After the headers come data words read from consecutive register addresses, starting just above the header pair. A 5-bit field inside the configuration word sets how many data words are sent.

Words leave on a valid/ready port. Each word carries its register address and a last flag. The block does not hold the data registers. It drives a read address to an outside register file and forwards the read data, which must be combinational, unchanged.

The controller is a four-state machine: `S_IDLE`, `S_HEAD_A` (first header), `S_HEAD_B` (mirror header) and `S_BODY` (data words). It has these transitions:
- `S_IDLE`→`S_HEAD_A` when a configuration is pending.
- `S_HEAD_A`→`S_HEAD_B` on a transfer.
- `S_HEAD_B`→`S_BODY` on a transfer when the length is non-zero.
- `S_HEAD_B`→`S_IDLE` on a transfer when the length is zero.
- `S_BODY`→`S_IDLE` on the transfer of the final data word.

A write that arrives while a burst is running is held and served once the machine is back in idle.

Top module: `burst_streamer`

## Requirements
- R1: After reset `out_valid` is 0, and it stays 0 while no configuration write occurs, whatever `out_ready` does.
- R2: A write (`cfg_wr` high at a rising edge) while idle makes `out_valid` rise after the second rising edge following it. After the first of those edges `out_valid` is still 0.
- R3: A packet presents addresses 0x9D, then 0x9E, then 0x9F upward. Each accepted word that is not the last is followed by a word whose address is one higher.
- R4: The word at 0x9D has bits 7:0 = 0x9F (the first data address), bits 12:8 = the burst length, bits 15:13 = 0 and bits 31:16 = 0xB0A7.
- R5: The word at 0x9E equals the configuration word ANDed with the mask 0x03FF00FF.
- R6: The burst length is configuration bits 25:21. Exactly that many data words follow the headers, so length 21 ends at address 0xB3 and length 31 ends at 0xBD.
- R7: A length of 0 sends only the two header words, and `out_last` is set on the 0x9E word.
- R8: `out_last` is 1 on the final word of a packet and 0 on every other word.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_addr`, `out_word` and `out_last` hold their values.
- R10: During data words `reg_raddr` equals `out_addr`, and `out_word` equals `reg_rdata`.
- R11: A write during a burst leaves that burst unchanged. After its last word is accepted, `out_valid` is 0 for one cycle and then a new packet built from the held configuration begins.
- R12: Several writes during one burst produce a single follow-on packet, built from the newest write. After that packet the port stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_data | input | 32 | Configuration word |
| reg_raddr | output | 8 | Register file read address |
| reg_rdata | input | 32 | Register file read data (combinational) |
| out_valid | output | 1 | Word available |
| out_ready | input | 1 | Consumer accepts word |
| out_addr | output | 8 | Register address of the presented word |
| out_word | output | 32 | Presented word |
| out_last | output | 1 | Final word of the packet |

## Verification
The bench covers these corner cases and the failure each one would expose:
- **Extreme lengths (0, 1, 21 and 31).** An off-by-one in the length compare sends one data word too many or too few, or misses the last flag after a header-only packet.
- **Back-pressure on every word.** A design that advances on valid alone skips addresses while the consumer stalls.
- **Mirror mask.** Configurations with bits set outside the mask check that the mask is applied, so unmasked bits would show up in the 0x9E word.
- **Writes during a burst.** These must be held rather than restarting the burst. A design that restarts would corrupt the running packet. A design that queues instead of overwriting would emit stale packets or a spurious extra packet.

// File: rtl/burst_stream_pkg.sv
package burst_stream_pkg;
    typedef enum logic [1:0] {
        S_IDLE,
        S_HEAD_A,
        S_HEAD_B,
        S_BODY
    } bst_state_e;
endpackage

// File: rtl/bst_cfg_hold.sv
module bst_cfg_hold #(
    parameter int CFG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CFG_W-1:0] wdata,
    input  logic             take,
    output logic             pend,
    output logic [CFG_W-1:0] pend_cfg
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend     <= 1'b0;
            pend_cfg <= '0;
        end else if (wr) begin
            pend     <= 1'b1;
            pend_cfg <= wdata;
        end else if (take) begin
            pend     <= 1'b0;
        end
    end

    // R12: the newest write is what stays pending
    a_r12_newest_kept: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> pend && pend_cfg == $past(wdata));
endmodule

// File: rtl/bst_addr_seq.sv
module bst_addr_seq #(
    parameter int              ADDR_W = 8,
    parameter int              LEN_W  = 5,
    parameter logic [ADDR_W-1:0] BASE = 8'h9F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [LEN_W-1:0]  len,
    output logic [ADDR_W-1:0] addr,
    output logic              at_last
);
    logic [LEN_W-1:0] idx;

    always_ff @(posedge clk) begin
        if (!rst_n)    idx <= '0;
        else if (load) idx <= '0;
        else if (step) idx <= idx + LEN_W'(1);
    end

    assign addr    = BASE + ADDR_W'(idx);
    assign at_last = (len != '0) && (idx == len - LEN_W'(1));

    // R3: each step moves the address up by one
    a_r3_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> addr == $past(addr) + ADDR_W'(1));
endmodule

// File: rtl/burst_streamer.sv
module burst_streamer
    import burst_stream_pkg::*;
#(
    parameter int                DATA_W      = 32,
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] HDR_ADDR    = 8'h9D,
    parameter int                LEN_LSB     = 21,
    parameter int                LEN_W       = 5,
    parameter logic [DATA_W-1:0] MIRROR_MASK = 32'h03FF_00FF,
    parameter logic [15:0]       HDR0_TAG    = 16'hB0A7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [DATA_W-1:0] cfg_data,
    output logic [ADDR_W-1:0] reg_raddr,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_word,
    output logic              out_last
);
    localparam logic [ADDR_W-1:0] MIRROR_ADDR = HDR_ADDR + ADDR_W'(1);
    localparam logic [ADDR_W-1:0] DATA_ADDR   = HDR_ADDR + ADDR_W'(2);

    bst_state_e        state, state_nx;
    logic [DATA_W-1:0] act_cfg;
    logic [LEN_W-1:0]  act_len;
    logic              pend, take, xfer, step, at_last;
    logic [DATA_W-1:0] pend_cfg;
    logic [ADDR_W-1:0] seq_addr;
    logic [DATA_W-1:0] hdr0;

    assign act_len = act_cfg[LEN_LSB +: LEN_W];
    assign xfer    = out_valid && out_ready;
    assign take    = (state == S_IDLE) && pend;
    assign step    = (state == S_BODY) && xfer && !at_last;

    bst_cfg_hold #(.CFG_W(DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(cfg_data),
        .take(take), .pend(pend), .pend_cfg(pend_cfg)
    );

    bst_addr_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BASE(DATA_ADDR)) u_seq (
        .clk(clk), .rst_n(rst_n), .load(take), .step(step),
        .len(act_len), .addr(seq_addr), .at_last(at_last)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (pend) state_nx = S_HEAD_A;
            S_HEAD_A: if (xfer) state_nx = S_HEAD_B;
            S_HEAD_B: if (xfer) state_nx = (act_len == '0) ? S_IDLE : S_BODY;
            S_BODY:   if (xfer && at_last) state_nx = S_IDLE;
        endcase
    end

    // state register and active configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            act_cfg <= '0;
        end else begin
            state <= state_nx;
            if (take) act_cfg <= pend_cfg;
        end
    end

    always_comb begin
        hdr0                       = '0;
        hdr0[ADDR_W-1:0]           = DATA_ADDR;
        hdr0[ADDR_W +: LEN_W]      = act_len;
        hdr0[DATA_W-1 -: 16]       = HDR0_TAG;
    end

    assign reg_raddr = seq_addr;

    // output logic
    always_comb begin
        out_valid = 1'b0;
        out_addr  = '0;
        out_word  = '0;
        out_last  = 1'b0;
        unique case (state)
            S_IDLE: ;
            S_HEAD_A: begin
                out_valid = 1'b1;
                out_addr  = HDR_ADDR;
                out_word  = hdr0;
            end
            S_HEAD_B: begin
                out_valid = 1'b1;
                out_addr  = MIRROR_ADDR;
                out_word  = act_cfg & MIRROR_MASK;
                out_last  = (act_len == '0);
            end
            S_BODY: begin
                out_valid = 1'b1;
                out_addr  = seq_addr;
                out_word  = reg_rdata;
                out_last  = at_last;
            end
        endcase
    end

    a_r9_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid && $stable(out_addr) && $stable(out_last));

    a_r3_addr_climb: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !out_last) |=> out_valid && out_addr == $past(out_addr) + ADDR_W'(1));

    a_r6_last_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last && state == S_BODY) |->
            out_addr == DATA_ADDR + ADDR_W'(act_len) - ADDR_W'(1));

    a_r7_hdr_only_last: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_addr == MIRROR_ADDR) |-> out_last == (act_len == '0));

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend && state == S_IDLE) |=> !out_valid);
endmodule

// File: tb/tb_burst_streamer.sv
module tb_burst_streamer;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 5;
    localparam logic [31:0] MASK = 32'h03FF_00FF;
    // each vector: {configuration word, stall-on-every-word flag}
    localparam logic [32:0] VECS [NVEC] = '{
        {32'h02A0_1234, 1'b0},   // length 21
        {32'h0000_00AB, 1'b1},   // length 0
        {32'hFC20_0055, 1'b1},   // length 1, bits outside mask
        {32'hFFFF_FFFF, 1'b0},   // length 31
        {32'h00A0_0F0F, 1'b1}    // length 5
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_data = '0;
    logic [7:0]  reg_raddr;
    logic [31:0] reg_rdata;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  out_addr;
    logic [31:0] out_word;
    logic        out_last;

    int n_chk = 0;
    int n_fail = 0;
    logic gap_valid;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign reg_rdata = {16'hDA7A, 8'h00, reg_raddr};

    burst_streamer dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
        .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_addr(out_addr), .out_word(out_word), .out_last(out_last)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // write while idle and check the start latency (R2)
    task automatic cfg_write(input logic [31:0] c);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_data = c;
        @(negedge clk);
        cfg_wr = 1'b0;
        chk(out_valid == 1'b0, "R2 not yet valid", {31'b0, out_valid}, 32'h0);
        @(negedge clk);
        chk(out_valid == 1'b1, "R2 valid after two edges", {31'b0, out_valid}, 32'h1);
    endtask

    // receive one packet; optional writes injected at word indices i1 and i2
    task automatic recv(input logic [31:0] c, input bit stall,
                        input int i1, input logic [31:0] c1,
                        input int i2, input logic [31:0] c2);
        int len = int'(c[25:21]);
        int n = len + 2;
        for (int i = 0; i < n; i++) begin
            logic [7:0]  ea;
            logic [31:0] ew;
            logic        el;
            int w = 0;
            while (!out_valid && w < 8) begin @(negedge clk); w++; end
            ea = 8'h9D + 8'(i);
            el = (i == n - 1);
            if (i == 0)      ew = {16'hB0A7, 3'b000, 5'(len), 8'h9F};
            else if (i == 1) ew = c & MASK;
            else             ew = {16'hDA7A, 8'h00, ea};
            chk(out_valid == 1'b1, "R3 word present", {31'b0, out_valid}, 32'h1);
            chk(out_addr == ea, "R3/R6 address", {24'b0, out_addr}, {24'b0, ea});
            if (i == 0)      chk(out_word == ew, "R4 header word", out_word, ew);
            else if (i == 1) chk(out_word == ew, "R5 mirror word", out_word, ew);
            else begin
                chk(out_word == ew, "R10 data word", out_word, ew);
                chk(reg_raddr == out_addr, "R10 read address", {24'b0, reg_raddr}, {24'b0, out_addr});
            end
            chk(out_last == el, (len == 0) ? "R7 last flag" : "R8 last flag", {31'b0, out_last}, {31'b0, el});
            if (stall) begin
                @(negedge clk);
                chk(out_valid && out_addr == ea && out_word == ew && out_last == el,
                    "R9 hold under stall", {23'b0, out_valid, out_addr}, {23'b0, 1'b1, ea});
            end
            out_ready = 1'b1;
            if (i == i1) begin cfg_wr = 1'b1; cfg_data = c1; end
            if (i == i2) begin cfg_wr = 1'b1; cfg_data = c2; end
            @(negedge clk);
            out_ready = 1'b0;
            cfg_wr = 1'b0;
        end
        gap_valid = out_valid;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        summary();
    end

    initial begin
        // R1 reset and idle with ready toggling
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 valid low in reset", {31'b0, out_valid}, 32'h0);
        rst_n = 1'b1;
        for (int k = 0; k < 6; k++) begin
            out_ready = k[0];
            @(negedge clk);
            chk(out_valid == 1'b0, "R1 idle without write", {31'b0, out_valid}, 32'h0);
        end
        out_ready = 1'b0;

        // vector table: R2..R10 over lengths and stall patterns
        for (int v = 0; v < NVEC; v++) begin
            cfg_write(VECS[v][32:1]);
            recv(VECS[v][32:1], VECS[v][0], -1, '0, -1, '0);
            chk(gap_valid == 1'b0, "R6 no extra words", {31'b0, gap_valid}, 32'h0);
        end

        // R11: write during burst is held and served after it
        cfg_write(32'h0040_0011);
        recv(32'h0040_0011, 1'b0, 3, 32'h0020_0022, -1, '0);
        chk(gap_valid == 1'b0, "R11 idle cycle between packets", {31'b0, gap_valid}, 32'h0);
        @(negedge clk);
        chk(out_valid == 1'b1, "R11 follow-on packet starts", {31'b0, out_valid}, 32'h1);
        recv(32'h0020_0022, 1'b1, -1, '0, -1, '0);

        // R12: two writes during one burst, newest wins, single follow-on
        cfg_write(32'h0060_0033);
        recv(32'h0060_0033, 1'b0, 1, 32'h0080_0044, 3, 32'h0020_0055);
        chk(gap_valid == 1'b0, "R12 idle cycle between packets", {31'b0, gap_valid}, 32'h0);
        @(negedge clk);
        recv(32'h0020_0055, 1'b0, -1, '0, -1, '0);
        for (int k = 0; k < 5; k++) begin
            chk(out_valid == 1'b0, "R12 no second follow-on", {31'b0, out_valid}, 32'h0);
            @(negedge clk);
        end
        summary();
    end
endmodule